// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two operands and a carry-in in a single combinational pass and returns the sum, the unsigned carry-out and a two's-complement overflow flag. The operand word is cut into 4-bit slices. Each slice forms bit-level propagate (XOR) and generate (AND) terms. It derives its three inner carries as flat sums of products from its own slice carry-in. It also reports a slice-wide propagate and a slice-wide generate.

A separate second-level unit turns the slice propagate/generate pairs and the external carry-in into the carry entering every slice, plus the final carry-out. It writes each of these as a flat sum of products, so no carry waits on a neighbour slice. The same result bits serve unsigned and signed callers. Carry-out reads as the unsigned result and overflow reads as the signed result.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^WIDTH for every input combination.
- R2: `cout` equals bit WIDTH of the unsigned sum `a` + `b` + `cin`; with `a` all ones, `b` = 1 and `cin` = 0, `sum` is 0 and `cout` is 1.
- R3: `ovf` is 1 exactly when the signed value of `a` plus the signed value of `b` plus `cin` lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1. This is the same as the carry into the most significant bit differing from the carry out of it.
- R4: `cout` and `ovf` are independent flags. At WIDTH 4: 0111+0111 and 0100+0100 give `ovf`=1 and `cout`=0; 1111+1111 gives `cout`=1 and `ovf`=0; 1000+1000 gives both flags set.
- R5: A carry-in crosses every slice when all bits propagate: `a` all ones, `b` = 0 and `cin` = 1 give `sum` = 0 and `cout` = 1. A slice that propagates on every bit never also reports a slice generate.
- R6: The carry entering each slice equals slice generate OR (slice propagate AND carry into the slice below). For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.
- R7: WIDTH is a parameter and must be a multiple of 4. The block gives correct results at 16 bits (the default) and at 4 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Result bits |
| cout | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Signed overflow flag |

## Verification
Hand-picked patterns separate the carry paths. A long all-propagate operand with a carry-in tests the full lookahead chain across every slice. Values sitting on slice boundaries (0x000F+1, 0x0FFF+1) catch a wrong slice carry that an in-slice carry would hide. Small 4-bit signed corner pairs separate overflow from carry-out, since they produce each flag alone and both together. Random vectors with both carry-in values then sweep mixed generate/propagate patterns and are compared against a plain integer reference.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int SLICE = 4;

  // Flat two-level carries for one slice: {c3,c2,c1,c0}
  function automatic logic [3:0] slice_carries(input logic [3:0] p, input logic [3:0] g,
                                               input logic c0);
    logic [3:0] c;
    c[0] = c0;
    c[1] = g[0] | (p[0] & c0);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
    return c;
  endfunction

  function automatic logic slice_prop(input logic [3:0] p);
    return p[3] & p[2] & p[1] & p[0];
  endfunction

  function automatic logic slice_gen(input logic [3:0] p, input logic [3:0] g);
    return g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
  endfunction

endpackage

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
(
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output logic       gp,
  output logic       gg,
  output logic       c_msb
);
  logic [3:0] p_bit;
  logic [3:0] g_bit;
  logic [3:0] c_bit;

  always_comb begin
    p_bit = a ^ b;
    g_bit = a & b;
    c_bit = slice_carries(p_bit, g_bit, cin);
    sum   = p_bit ^ c_bit;
    gp    = slice_prop(p_bit);
    gg    = slice_gen(p_bit, g_bit);
    c_msb = c_bit[3];
  end

  always_comb begin
    // R5
    gen_excl_chk: assert (!(gp && gg));
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int NGRP = 4
) (
  input  logic [NGRP-1:0] gp,
  input  logic [NGRP-1:0] gg,
  input  logic            c0,
  output logic [NGRP:0]   carry
);
  // Each carry is a flat sum of products over the slices below it
  always_comb begin
    carry[0] = c0;
    for (int k = 1; k <= NGRP; k++) begin
      logic acc;
      logic term;
      acc = c0;
      for (int m = 0; m < k; m++) acc = acc & gp[m];
      for (int j = 0; j < k; j++) begin
        term = gg[j];
        for (int m = j + 1; m < k; m++) term = term & gp[m];
        acc = acc | term;
      end
      carry[k] = acc;
    end
  end

  always_comb begin
    for (int k = 0; k < NGRP; k++) begin
      // R6
      grp_carry_chk: assert (carry[k+1] == (gg[k] | (gp[k] & carry[k])));
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int NGRP = WIDTH / cla_pkg::SLICE;

  logic [NGRP-1:0] gp;
  logic [NGRP-1:0] gg;
  logic [NGRP-1:0] cmsb;
  logic [NGRP:0]   carry;

  cla_lookahead #(.NGRP(NGRP)) u_look (
    .gp(gp), .gg(gg), .c0(cin), .carry(carry)
  );

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_slice
    cla_slice u_slice (
      .a    (a[gi*4 +: 4]),
      .b    (b[gi*4 +: 4]),
      .cin  (carry[gi]),
      .sum  (sum[gi*4 +: 4]),
      .gp   (gp[gi]),
      .gg   (gg[gi]),
      .c_msb(cmsb[gi])
    );

    always_comb begin
      // R1
      slice_top_bit_chk: assert (sum[gi*4+3] == (a[gi*4+3] ^ b[gi*4+3] ^ cmsb[gi]));
    end
  end

  assign cout = carry[NGRP];
  assign ovf  = cmsb[NGRP-1] ^ cout;

  always_comb begin
    // R2
    total_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    // R3
    no_overflow_chk: assert (ovf == ((a[WIDTH-1] == b[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1])));
  end
endmodule

// File: tb/sim_cla_adder.sv
module sim_cla_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [15:0] a16, b16, s16;
  logic        c16, co16, ov16;
  logic [3:0]  a4, b4, s4;
  logic        c4, co4, ov4;

  int total = 0;
  int bad   = 0;

  cla_adder #(.WIDTH(16)) u0 (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16), .ovf(ov16));
  cla_adder #(.WIDTH(4))  u1 (.a(a4), .b(b4), .cin(c4), .sum(s4), .cout(co4), .ovf(ov4));

  task automatic check16(input logic [15:0] x, input logic [15:0] y, input logic ci, input string tag);
    int ux, uy, sx, sy, ut, st;
    logic [15:0] es;
    logic eco, eov;
    @(posedge clk);
    a16 = x; b16 = y; c16 = ci;
    @(negedge clk);
    ux = int'(x); uy = int'(y);
    sx = x[15] ? ux - 65536 : ux;
    sy = y[15] ? uy - 65536 : uy;
    ut = ux + uy + int'(ci);
    st = sx + sy + int'(ci);
    es  = 16'(ut % 65536);
    eco = (ut >= 65536);
    eov = (st > 32767) || (st < -32768);
    total++;
    if (s16 !== es || co16 !== eco || ov16 !== eov) begin
      bad++;
      $display("FAIL %s: %h+%h+%0d got sum=%h cout=%0d ovf=%0d expected sum=%h cout=%0d ovf=%0d",
               tag, x, y, ci, s16, co16, ov16, es, eco, eov);
    end
  endtask

  task automatic check4(input logic [3:0] x, input logic [3:0] y, input logic ci, input string tag);
    int ux, uy, sx, sy, ut, st;
    logic [3:0] es;
    logic eco, eov;
    @(posedge clk);
    a4 = x; b4 = y; c4 = ci;
    @(negedge clk);
    ux = int'(x); uy = int'(y);
    sx = x[3] ? ux - 16 : ux;
    sy = y[3] ? uy - 16 : uy;
    ut = ux + uy + int'(ci);
    st = sx + sy + int'(ci);
    es  = 4'(ut % 16);
    eco = (ut >= 16);
    eov = (st > 7) || (st < -8);
    total++;
    if (s4 !== es || co4 !== eco || ov4 !== eov) begin
      bad++;
      $display("FAIL %s: %h+%h+%0d got sum=%h cout=%0d ovf=%0d expected sum=%h cout=%0d ovf=%0d",
               tag, x, y, ci, s4, co4, ov4, es, eco, eov);
    end
  endtask

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a4 = '0; b4 = '0; c4 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (s16 !== 16'h0 || co16 !== 1'b0 || ov16 !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle: got sum=%h cout=%0d ovf=%0d expected sum=0000 cout=0 ovf=0", s16, co16, ov16);
    end
    check16(16'h1234, 16'h4321, 1'b0, "R1 plain");
    check16(16'hFFFF, 16'h0001, 1'b0, "R2 wrap");
    check16(16'h7FFF, 16'h0001, 1'b0, "R3 pos overflow");
    check16(16'h8000, 16'hFFFF, 1'b0, "R3 neg overflow");
    check16(16'hFFFF, 16'h0000, 1'b1, "R5 full propagate");
    check16(16'h000F, 16'h0001, 1'b0, "R6 slice0 boundary");
    check16(16'h0FFF, 16'h0001, 1'b0, "R6 slice2 boundary");
    check16(16'h00F0, 16'h0010, 1'b0, "R6 slice1 generate");
    check4(4'h7, 4'h7, 1'b0, "R4 7+7");
    check4(4'h4, 4'h4, 1'b0, "R4 4+4");
    check4(4'hF, 4'hF, 1'b0, "R4 -1+-1");
    check4(4'h8, 4'h8, 1'b0, "R4 -8+-8");
    check4(4'hF, 4'h0, 1'b1, "R7 4-bit propagate");
    for (int n = 0; n < 300; n++)
      check16(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 R3 random");
    for (int n = 0; n < 100; n++)
      check4(4'($urandom), 4'($urandom), 1'($urandom), "R7 random 4-bit");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule